// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that software drives through a small file of 32-bit registers. Software picks the character length, bit order, loopback and serial clock rate in a mode register. It then writes a word to the transmit register. The block shifts the low-order bits of that word out on MOSI and captures the same number of bits from MISO, or from its own transmit path in loopback. When the character is complete, the captured bits land right-justified in the receive register.

Two status flags tell software where a transfer stands: one shows that a received character is waiting, and the other shows that the transmitter is free. A mask register routes either flag onto a single interrupt line. Chip selects are driven outside the block.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the mode, mask and command registers read 0, the receive register reads 0, the event register reads 0x0000_0100 (only the transmitter-free flag set), SCK is low and the interrupt is low.
- R2: A write to word index 4 (transmit) starts a character only when mode bit 24 (enable) and mode bit 25 (master) are both 1 and no character is in flight. Any other transmit write is ignored: no SCK activity, and the transmit register keeps its old value when read back.
- R3: Mode bits 23:20 give the character length: code 0 is 32 bits, codes 3 to 15 are code+1 bits, and codes 1 and 2 are 4 bits. Only the low-order length bits of the transmit word are sent, and the receive register holds the character right-justified with zeros above it.
- R4: With mode bit 26 set the character is shifted MSB first, both out and in. With mode bit 26 clear it is shifted LSB first.
- R5: With mode bit 30 set the receiver takes its bits from the transmit data and MISO is ignored.
- R6: SCK idles low and has a period of 4*(P+1) system clocks, where P is mode bits 19:16, with a high phase and a low phase of 2*(P+1) cycles each. MOSI changes only at the start and after falling edges, and MISO is sampled on rising edges. The receive flag sets exactly len*4*(P+1) cycles after the clock edge that accepted the transmit write.
- R7: Event bit 9 (receive-not-empty) sets when a character completes. It stays set through reads of any register and clears only when a 1 is written to event bit 9. If completion and clear land in the same cycle, the set wins.
- R8: Event bit 8 (transmitter-free) is a live status: it is 1 while idle and 0 from the accepted transmit write until the character completes. Writes to the event register do not change it.
- R9: The interrupt output is high exactly when some event bit is set and the matching bit of the mask register (word index 2) is set. An all-zero mask keeps it low.
- R10: Word indices are: 0 mode, 1 event, 2 mask, 3 command, 4 transmit, 5 receive. Mode, mask and command read back as written. Writes to the receive register are ignored, and unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Masked event interrupt |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench stresses the length decode at its edges: code 0 for 32 bits, code 3, and the illegal codes 1 and 2. A decoder that got these wrong would send the wrong number of SCK pulses and leave stray or missing bits in the receive word. It rebuilds the MOSI stream and drives MISO from a slave shift register in both bit orders, so a design that swapped the order on only one side would fail. It runs loopback with MISO carrying unrelated data, to expose a receive path that still listens to the pin. It measures every SCK half period and the total latency to the receive flag, which catches an off-by-one in the prescaler. Writes while disabled, while not master and while busy must leave the transfer and the transmit register untouched. The flag checks show that reading the receive register does not clear its flag and that the interrupt follows the mask.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;

  localparam int REG_MODE  = 0;
  localparam int REG_EVENT = 1;
  localparam int REG_MASK  = 2;
  localparam int REG_CMD   = 3;
  localparam int REG_TX    = 4;
  localparam int REG_RX    = 5;

  localparam int MODE_LOOP_BIT = 30;
  localparam int MODE_MSB_BIT  = 26;
  localparam int MODE_MSTR_BIT = 25;
  localparam int MODE_EN_BIT   = 24;
  localparam int MODE_LEN_LSB  = 20;
  localparam int MODE_PRE_LSB  = 16;

  localparam int EV_RXNE_BIT = 9;
  localparam int EV_TXNF_BIT = 8;

  // Character length in bits from the 4-bit length code.
  function automatic logic [LEN_W-1:0] char_bits(input logic [3:0] code);
    if (code == 4'd0)      return LEN_W'(32);
    else if (code < 4'd3)  return LEN_W'(4);
    else                   return {2'b00, code} + LEN_W'(1);
  endfunction

  // Mask covering the low n bits of a word.
  function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] n);
    if (n >= LEN_W'(WORD_W)) return '1;
    else return (WORD_W'(1) << n) - WORD_W'(1);
  endfunction

  // Position within the word of the k-th bit on the wire.
  function automatic logic [4:0] bit_index(input logic [LEN_W-1:0] k,
                                           input logic [LEN_W-1:0] n,
                                           input logic msb_first);
    logic [LEN_W-1:0] t;
    t = msb_first ? (n - LEN_W'(1) - k) : k;
    return t[4:0];
  endfunction
endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv #(
  parameter int PRESC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  localparam int CNT_W = PRESC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // Half period is 2*(presc+1) cycles, so the terminal count is {presc,1}.
  assign limit = {presc, 1'b1};
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_bits,
  input  logic              msb_first,
  input  logic              loopback,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  input  logic              tick,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] txd_q, rxd_q;
  logic [LEN_W-1:0]  k_q, nb_q;
  logic              msb_q, lp_q, busy_q, sck_q;
  logic [4:0]        idx;
  logic              rx_bit;
  logic              last_bit;

  assign idx      = bit_index(k_q, nb_q, msb_q);
  assign mosi     = busy_q & txd_q[idx];
  assign rx_bit   = lp_q ? txd_q[idx] : miso;
  assign last_bit = (k_q == nb_q - LEN_W'(1));
  assign done     = busy_q & tick & sck_q & last_bit;
  assign busy     = busy_q;
  assign sck      = sck_q;
  assign rx_word  = rxd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= '0;
      rxd_q  <= '0;
      k_q    <= '0;
      nb_q   <= LEN_W'(32);
      msb_q  <= 1'b0;
      lp_q   <= 1'b0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else if (start && !busy_q) begin
      txd_q  <= tx_word & len_mask(len_bits);
      rxd_q  <= '0;
      k_q    <= '0;
      nb_q   <= len_bits;
      msb_q  <= msb_first;
      lp_q   <= loopback;
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_q      <= 1'b1;
        rxd_q[idx] <= rx_bit;
      end else begin
        sck_q <= 1'b0;
        if (last_bit) busy_q <= 1'b0;
        else          k_q    <= k_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int PRESC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  input  logic               busy,
  input  logic               done,
  input  logic [WORD_W-1:0]  rx_word,
  output logic               start,
  output logic               ev_clear,
  output logic               rxne,
  output logic               txnf,
  output logic [WORD_W-1:0]  mask,
  output logic               irq,
  output logic [WORD_W-1:0]  tx_word,
  output logic [LEN_W-1:0]   len_bits,
  output logic               msb_first,
  output logic               loopback,
  output logic [PRESC_W-1:0] presc
);
  logic [WORD_W-1:0] mode_q, mask_q, cmd_q, tx_q, rx_q;
  logic              rxne_q;
  logic [WORD_W-1:0] event_w;
  logic              wr_en;

  assign wr_en = sel & wr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  assign start = wr_en && hit(addr, REG_TX) && mode_q[MODE_EN_BIT]
                 && mode_q[MODE_MSTR_BIT] && !busy;
  assign ev_clear = wr_en && hit(addr, REG_EVENT) && wdata[EV_RXNE_BIT];

  assign txnf = !busy;
  assign rxne = rxne_q;
  assign mask = mask_q;

  always_comb begin
    event_w = '0;
    event_w[EV_RXNE_BIT] = rxne_q;
    event_w[EV_TXNF_BIT] = txnf;
  end

  assign irq = |(event_w & mask_q);

  assign tx_word   = wdata;
  assign len_bits  = char_bits(mode_q[MODE_LEN_LSB +: 4]);
  assign msb_first = mode_q[MODE_MSB_BIT];
  assign loopback  = mode_q[MODE_LOOP_BIT];
  assign presc     = mode_q[MODE_PRE_LSB +: PRESC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
      cmd_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxne_q <= 1'b0;
    end else begin
      if (wr_en && hit(addr, REG_MODE)) mode_q <= wdata;
      if (wr_en && hit(addr, REG_MASK)) mask_q <= wdata;
      if (wr_en && hit(addr, REG_CMD))  cmd_q  <= wdata;
      if (start)                        tx_q   <= wdata;
      if (done)                         rx_q   <= rx_word;
      if (done)          rxne_q <= 1'b1;
      else if (ev_clear) rxne_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, REG_MODE))       rdata = mode_q;
    else if (hit(addr, REG_EVENT)) rdata = event_w;
    else if (hit(addr, REG_MASK))  rdata = mask_q;
    else if (hit(addr, REG_CMD))   rdata = cmd_q;
    else if (hit(addr, REG_TX))    rdata = tx_q;
    else if (hit(addr, REG_RX))    rdata = rx_q;
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int PRESC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic               start_w, done_w, tick_w, busy_w;
  logic               ev_clear_w, rxne_w, txnf_w;
  logic [WORD_W-1:0]  mask_w, tx_word_w, rx_word_w;
  logic [LEN_W-1:0]   len_w;
  logic               msb_w, loop_w;
  logic [PRESC_W-1:0] presc_w;

  spi_host_regs #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy_w), .done(done_w),
    .rx_word(rx_word_w), .start(start_w), .ev_clear(ev_clear_w),
    .rxne(rxne_w), .txnf(txnf_w), .mask(mask_w), .irq(irq),
    .tx_word(tx_word_w), .len_bits(len_w), .msb_first(msb_w),
    .loopback(loop_w), .presc(presc_w)
  );

  spi_host_clkdiv #(.PRESC_W(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .presc(presc_w), .tick(tick_w)
  );

  spi_host_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_w), .len_bits(len_w),
    .msb_first(msb_w), .loopback(loop_w), .tx_word(tx_word_w), .miso(miso),
    .tick(tick_w), .busy(busy_w), .sck(sck), .mosi(mosi), .done(done_w),
    .rx_word(rx_word_w)
  );
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        sck,
  input logic        tick,
  input logic        done,
  input logic        start,
  input logic        rxne,
  input logic        txnf,
  input logic        ev_clear,
  input logic [31:0] mask,
  input logic        irq
);
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  assert_sck_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_rxne_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rxne);
  assert_rxne_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxne && !ev_clear) |=> rxne);
  assert_txnf_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !txnf);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && txnf));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 32'd0) |-> !irq);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .sck(sck), .tick(tick_w),
  .done(done_w), .start(start_w), .rxne(rxne_w), .txnf(txnf_w),
  .ev_clear(ev_clear_w), .mask(mask_w), .irq(irq)
);

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq, sck, mosi;
  logic        miso = 1'b0;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  spi_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  function automatic int exp_len(input logic [3:0] code);
    case (code)
      4'd0:       return 32;
      4'd1, 4'd2: return 4;
      default:    return int'(code) + 1;
    endcase
  endfunction

  function automatic logic [31:0] low_ones(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_mode(input logic [3:0] code,
      input logic [3:0] pr, input bit msb, input bit lp);
    return (32'(lp) << 30) | (32'(msb) << 26) | (32'd1 << 25) |
           (32'd1 << 24) | (32'(code) << 20) | (32'(pr) << 16);
  endfunction

  task automatic xfer(input logic [3:0] code, input logic [3:0] pr,
                      input bit msb, input bit lp, input logic [31:0] txv,
                      input logic [31:0] sv);
    int n, half, cyc, last, tog, badhalf;
    logic prev;
    logic [31:0] sr, capm, lm, d;
    n = exp_len(code); half = 2 * (int'(pr) + 1); lm = low_ones(n);
    wr_reg(0, mk_mode(code, pr, msb, lp));
    sr = sv & lm;
    miso = msb ? sr[n-1] : sr[0];
    wr_reg(4, txv);
    bus_addr = 3'd1; #1;
    check("R8 busy flag low after accepted write", 32'(bus_rdata[8]), 32'd0);
    cyc = 0; last = 0; tog = 0; badhalf = 0; prev = 1'b0; capm = '0;
    while (!bus_rdata[9] && cyc < 5000) begin
      @(negedge clk); #1; cyc++;
      if (sck !== prev) begin
        if (cyc - last != half) badhalf++;
        last = cyc; tog++;
        if (sck) begin
          if (msb) capm = (capm << 1) | 32'(mosi);
          else     capm = (capm >> 1) | (32'(mosi) << (n - 1));
        end else begin
          if (msb) begin sr = sr << 1; miso = sr[n-1]; end
          else     begin sr = sr >> 1; miso = sr[0];   end
        end
        prev = sck;
      end
    end
    check("R6 latency to receive flag", 32'(cyc), 32'(n * 4 * (int'(pr) + 1)));
    check("R6 half period mismatches", 32'(badhalf), 32'd0);
    check("R3 sck edge count", 32'(tog), 32'(2 * n));
    check("R4 mosi bit stream", capm, txv & lm);
    check("R8 free flag after completion", 32'(bus_rdata[8]), 32'd1);
    rd_reg(5, d);
    check(lp ? "R5 loopback receive" : "R3 R4 received word", d,
          (lp ? txv : sv) & lm);
    rd_reg(1, d);
    check("R7 flag survives receive read", 32'(d[9]), 32'd1);
    wr_reg(1, 32'h0000_0200);
    rd_reg(1, d);
    check("R7 W1C clears receive flag", d, 32'h0000_0100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual timeout expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seed_v;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(0, d); check("R1 mode reset", d, 32'd0);
    rd_reg(1, d); check("R1 event reset", d, 32'h0000_0100);
    rd_reg(2, d); check("R1 mask reset", d, 32'd0);
    rd_reg(5, d); check("R1 rx reset", d, 32'd0);
    check("R1 sck idle", 32'(sck), 32'd0);
    check("R1 irq idle", 32'(irq), 32'd0);

    // R10 register map
    wr_reg(3, 32'hA5A5_0F0F); rd_reg(3, d); check("R10 command readback", d, 32'hA5A5_0F0F);
    wr_reg(2, 32'h0000_0000); rd_reg(2, d); check("R10 mask readback", d, 32'd0);
    rd_reg(6, d); check("R10 unused index", d, 32'd0);
    rd_reg(7, d); check("R10 unused index 7", d, 32'd0);

    // R2 write with enable clear is ignored
    wr_reg(0, 32'h0270_0000);
    rd_reg(0, d); check("R10 mode readback", d, 32'h0270_0000);
    wr_reg(4, 32'h1234_5678);
    repeat (20) begin
      @(negedge clk); #1;
      if (sck !== 1'b0) begin errors++; $display("FAIL R2 sck moved while disabled actual 1 expected 0"); end
    end
    checks++;
    rd_reg(4, d); check("R2 tx unchanged while disabled", d, 32'd0);
    rd_reg(1, d); check("R2 no transfer while disabled", d, 32'h0000_0100);
    // R2 master bit clear
    wr_reg(0, 32'h0170_0000);
    wr_reg(4, 32'h0000_0055);
    repeat (20) @(negedge clk);
    rd_reg(4, d); check("R2 tx unchanged without master", d, 32'd0);
    rd_reg(1, d); check("R2 no transfer without master", d, 32'h0000_0100);

    // Directed length and order corners
    xfer(4'd0, 4'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h1357_9BDF); // R3 32 bits
    xfer(4'd0, 4'd1, 1'b0, 1'b0, 32'h8000_0001, 32'hF00F_1234); // R4 LSB first
    xfer(4'd3, 4'd0, 1'b1, 1'b0, 32'hFFFF_FFF9, 32'hFFFF_FFF6); // R3 4 bits
    xfer(4'd1, 4'd2, 1'b0, 1'b0, 32'h0000_00F3, 32'h0000_00A5); // R3 code 1
    xfer(4'd2, 4'd0, 1'b1, 1'b1, 32'h0000_000C, 32'h0000_0003); // R5 code 2
    xfer(4'd15, 4'd0, 1'b1, 1'b1, 32'h0001_F00D, 32'hFFFF_0000); // R5 16 bits
    xfer(4'd3, 4'd15, 1'b0, 1'b0, 32'h0000_0006, 32'h0000_0009); // R6 slow

    // R2 write while busy is ignored
    wr_reg(0, mk_mode(4'd7, 4'd0, 1'b1, 1'b1));
    wr_reg(4, 32'h0000_00C3);
    repeat (6) @(negedge clk);
    wr_reg(4, 32'h0000_003C);
    repeat (80) @(negedge clk);
    rd_reg(5, d); check("R2 busy write ignored rx", d, 32'h0000_00C3);
    rd_reg(4, d); check("R2 busy write ignored tx", d, 32'h0000_00C3);
    wr_reg(5, 32'hFFFF_FFFF);
    rd_reg(5, d); check("R10 rx write ignored", d, 32'h0000_00C3);

    // R9 interrupt masking
    rd_reg(1, d); check("R9 receive flag pending", d, 32'h0000_0300);
    check("R9 zero mask no irq", 32'(irq), 32'd0);
    wr_reg(2, 32'h0000_0200); #1;
    check("R9 irq from receive flag", 32'(irq), 32'd1);
    wr_reg(1, 32'h0000_0300); #1;
    check("R9 irq drops after W1C", 32'(irq), 32'd0);
    rd_reg(1, d); check("R8 write does not clear free flag", d, 32'h0000_0100);
    wr_reg(2, 32'h0000_0100); #1;
    check("R9 irq from free flag", 32'(irq), 32'd1);
    wr_reg(2, 32'hFFFF_FCFF); #1;
    check("R9 other mask bits no irq", 32'(irq), 32'd0);
    wr_reg(2, 32'd0);

    // Random transfers
    for (int i = 0; i < 40; i++) begin
      xfer(4'($urandom()), 4'($urandom_range(0, 3)), 1'($urandom()),
           1'($urandom()), $urandom(), $urandom());
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule